// File: doc/BRIEF.md
# SAR Converter Control and Bus Logic

This block is the digital core of a 12-bit successive-approximation converter. A host raises a convert-start line that has no fixed phase relation to the converter clock. The block samples that line through a synchronizer and turns its rising edge into a conversion. It then walks a trial code from the most significant bit down. The trial code feeds an external DAC, and a one-bit comparator decision comes back. At the end the block holds the final code and releases an active-low busy line. The comparator, the DAC and the track/hold stage sit outside the block.

The result is read over a parallel port. The block raises a drive-enable for the pad tri-state buffers only when chip-select and read are both low and no conversion is running. A mode pin puts the block into a low-power state. The first conversion after wake-up is a dummy: its code is thrown away and the result stays marked invalid.

The controller has three states. ST_IDLE goes to ST_PWRDN on a sleep request, or to ST_CONV on a synchronized start edge; the sleep request wins when both occur. ST_CONV returns to ST_IDLE on its last cycle. ST_PWRDN returns to ST_IDLE once the mode pin is high.

Top module: `sar_ctrl`

## Requirements
- R1: A rising edge on conv_start starts a conversion whatever cs_n and rd_n are doing. busy_n goes low right after the third rising clock edge that follows the rise.
- R2: busy_n stays low for exactly 27 clock cycles (two per bit plus three padding cycles) and then returns high.
- R3: cmp_in high means the analog input is at or above the level of dac_code. With transitions at half-LSB points, an input of v half-LSB units gives the code min(4095, floor((v+1)/2)) in straight binary. Full scale minus 3/2 LSB (v = 8189) is the first input that gives all ones.
- R4: In the cycle after busy_n falls, dac_code holds 12'h800, the MSB trial. Each bit is then settled for one clock and decided on the next clock, MSB first.
- R5: data_oe is high only when cs_n = 0, rd_n = 0 and the block is idle (not converting and not powered down). Whenever data_oe is low, data_q reads zero.
- R6: A rising edge on conv_start while busy_n is low is ignored. The running conversion ends on schedule and no second conversion follows.
- R7: With mode low and rd_n high in the idle state, the block enters power-down. It clears result_valid and the held code, ignores conv_start edges, and stays there until mode returns high.
- R8: mode low while rd_n is low does not enter power-down. The held code and result_valid are kept.
- R9: The first conversion after power-down is a dummy. It runs the full 27 cycles but leaves result_valid low and the held code at zero. The next conversion loads its code and sets result_valid.
- R10: After reset, busy_n is high, data_oe is low, data_q is zero and result_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Asynchronous convert-start; the rising edge starts a conversion |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| pwr_mode | input | 1 | High for normal operation, low to request power-down |
| cmp_in | input | 1 | Comparator decision: input at or above the DAC level |
| busy_n | output | 1 | Low while a conversion runs |
| dac_code | output | 12 | Trial code for the external DAC |
| data_oe | output | 1 | Drive-enable for the pad tri-state buffers |
| data_q | output | 12 | Held result, zero when not enabled |
| result_valid | output | 1 | High when the held code comes from a real conversion |

## Verification
The bench goes after the ends of the transfer curve: zero input, half an LSB, one step below and at the all-ones threshold, and overrange. A design with an off-by-one trial comparison or an inverted decision would return a neighbouring code or a mirrored one. It re-triggers conv_start in the middle of a conversion; a design that does not guard its start edge would restart and stretch busy_n past 27 cycles. It reads while busy, while deselected and while asleep, where a loose enable would drive the bus. It also checks the wake-up dummy conversion, which a design without a dummy flag would report as a valid result.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_PWRDN = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_pulse = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             decide,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] trial
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial <= '0;
            ptr_q <= '0;
        end else if (load) begin
            trial <= MSB_ONLY;
            ptr_q <= MSB_ONLY;
        end else if (decide) begin
            trial <= (cmp_in ? trial : (trial & ~ptr_q)) | (ptr_q >> 1);
            ptr_q <= ptr_q >> 1;
        end
    end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH       = 12,
    parameter int PAD_CYCLES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             pwr_mode,
    input  logic             cmp_in,
    output logic             busy_n,
    output logic [WIDTH-1:0] dac_code,
    output logic             data_oe,
    output logic [WIDTH-1:0] data_q,
    output logic             result_valid
);
    localparam int CONV_CYCLES = 2 * WIDTH + PAD_CYCLES;
    localparam int CNT_W       = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] DECIDE_END = CNT_W'(2 * WIDTH);

    sar_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             start_pulse;
    logic             last_cycle;
    logic             decide;
    logic             load;
    logic             enter_pd;
    logic             finish;
    logic             dummy_q;
    logic [WIDTH-1:0] result_q;
    logic [WIDTH-1:0] trial;

    sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (conv_start),
        .rise_pulse (start_pulse)
    );

    sar_trial #(.WIDTH(WIDTH)) u_trial (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .decide (decide),
        .cmp_in (cmp_in),
        .trial  (trial)
    );

    assign last_cycle = (state_q == ST_CONV) && (cnt_q == LAST_CNT);
    assign decide     = (state_q == ST_CONV) && cnt_q[0] && (cnt_q < DECIDE_END);

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!pwr_mode && rd_n)  state_nx = ST_PWRDN;
                else if (start_pulse)   state_nx = ST_CONV;
            end
            ST_CONV: begin
                if (last_cycle) state_nx = ST_IDLE;
            end
            ST_PWRDN: begin
                if (pwr_mode) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign load     = (state_q == ST_IDLE) && (state_nx == ST_CONV);
    assign enter_pd = (state_q == ST_IDLE) && (state_nx == ST_PWRDN);
    assign finish   = last_cycle;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Cycle counter within a conversion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q != ST_CONV) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    // Held result, valid flag and dummy tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q     <= '0;
            result_valid <= 1'b0;
            dummy_q      <= 1'b0;
        end else if (enter_pd) begin
            result_q     <= '0;
            result_valid <= 1'b0;
            dummy_q      <= 1'b1;
        end else if (finish) begin
            if (dummy_q) begin
                dummy_q <= 1'b0;
            end else begin
                result_q     <= trial;
                result_valid <= 1'b1;
            end
        end
    end

    // Output logic
    always_comb begin
        busy_n   = (state_q != ST_CONV);
        dac_code = trial;
        data_oe  = !cs_n && !rd_n && (state_q == ST_IDLE);
        data_q   = data_oe ? result_q : '0;
    end
endmodule

// File: rtl/sar_ctrl_checker.sv
module sar_ctrl_checker #(
    parameter int WIDTH      = 12,
    parameter int PAD_CYCLES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             rd_n,
    input logic             busy_n,
    input logic [WIDTH-1:0] dac_code,
    input logic             data_oe,
    input logic [WIDTH-1:0] data_q,
    input logic             result_valid
);
    localparam int CONV_CYCLES = 2 * WIDTH + PAD_CYCLES;
    localparam int RUN_W       = $clog2(CONV_CYCLES + 2) + 1;
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_run <= '0;
        else if (!busy_n) low_run <= low_run + 1'b1;
        else              low_run <= '0;
    end

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_run == RUN_W'(CONV_CYCLES)));

    assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run <= RUN_W'(CONV_CYCLES)));

    assert_oe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!cs_n && !rd_n && busy_n));

    assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_q == '0));

    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> (dac_code == MSB_ONLY));

    assert_valid_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $rose(busy_n));
endmodule

bind sar_ctrl sar_ctrl_checker #(.WIDTH(WIDTH), .PAD_CYCLES(PAD_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .busy_n       (busy_n),
    .dac_code     (dac_code),
    .data_oe      (data_oe),
    .data_q       (data_q),
    .result_valid (result_valid)
);

// File: tb/sar_ctrl_bench.sv
`timescale 1ns/1ps
module sar_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        pwr_mode = 1'b1;
    logic        cmp_in;
    logic        busy_n;
    logic [11:0] dac_code;
    logic        data_oe;
    logic [11:0] data_q;
    logic        result_valid;

    int vin2 = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // behavioural comparator: input (half-LSB units) vs DAC transition level
    assign cmp_in = (2 * int'(dac_code) <= vin2 + 1);

    sar_ctrl u_sar_ctrl (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cs_n(cs_n),
        .rd_n(rd_n), .pwr_mode(pwr_mode), .cmp_in(cmp_in), .busy_n(busy_n),
        .dac_code(dac_code), .data_oe(data_oe), .data_q(data_q),
        .result_valid(result_valid)
    );

    function automatic int exp_code(input int v);
        int c;
        c = (v + 1) / 2;
        if (c > 4095) c = 4095;
        return c;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_conv(input int v, input bit retrig);
        vin2 = v;
        @(negedge clk);
        conv_start = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy_n low after third edge", int'(busy_n), 0);
        chk("R4 first trial code", int'(dac_code), 'h800);
        for (int i = 1; i < 27; i++) begin
            @(negedge clk);
            if (retrig && i == 6) conv_start = 1'b0;
            if (retrig && i == 8) conv_start = 1'b1;
            if (i == 12) begin
                cs_n = 1'b0; rd_n = 1'b0; #1;
                chk("R5 no drive while busy", int'(data_oe), 0);
                cs_n = 1'b1; rd_n = 1'b1;
            end
        end
        chk("R2 busy_n still low at cycle 26", int'(busy_n), 0);
        @(negedge clk);
        chk("R2 busy_n high after 27 cycles", int'(busy_n), 1);
        if (retrig) begin
            repeat (6) @(negedge clk);
            chk("R6 no second conversion", int'(busy_n), 1);
        end
        conv_start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_chk(input string what, input int exp, input int exp_valid);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk({what, " oe"}, int'(data_oe), 1);
        chk({what, " code"}, int'(data_q), exp);
        chk({what, " valid"}, int'(result_valid), exp_valid);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy_n", int'(busy_n), 1);
        chk("R10 data_oe", int'(data_oe), 0);
        chk("R10 data_q", int'(data_q), 0);
        chk("R10 result_valid", int'(result_valid), 0);

        // R3 directed corners
        run_conv(0, 1'b0);    read_chk("R3 zero", exp_code(0), 1);
        run_conv(1, 1'b0);    read_chk("R3 half LSB", exp_code(1), 1);
        run_conv(8188, 1'b0); read_chk("R3 below top", exp_code(8188), 1);
        run_conv(8189, 1'b0); read_chk("R3 FS-3/2LSB", 4095, 1);
        run_conv(8400, 1'b0); read_chk("R3 overrange", 4095, 1);
        run_conv(4095, 1'b0); read_chk("R3 midscale", 2048, 1);

        // R3 random inputs
        for (int k = 0; k < 20; k++) begin
            int v;
            v = int'($urandom % 8192);
            run_conv(v, 1'b0);
            read_chk("R3 random", exp_code(v), 1);
        end

        // R1 start works with chip deselected, R6 re-trigger ignored
        run_conv(3000, 1'b1);
        read_chk("R6 code after retrigger", exp_code(3000), 1);

        // R5 read gating at idle
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R5 deselected no drive", int'(data_oe), 0);
        chk("R5 deselected data zero", int'(data_q), 0);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        chk("R5 rd high no drive", int'(data_oe), 0);
        cs_n = 1'b1;

        // R8 mode low with read low does not sleep
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; pwr_mode = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 still driving", int'(data_oe), 1);
        chk("R8 code kept", int'(data_q), exp_code(3000));
        chk("R8 valid kept", int'(result_valid), 1);
        pwr_mode = 1'b1; cs_n = 1'b1; rd_n = 1'b1;

        // R7 power-down
        @(negedge clk);
        pwr_mode = 1'b0;
        @(negedge clk);
        chk("R7 valid cleared", int'(result_valid), 0);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk("R7 no drive asleep", int'(data_oe), 0);
        cs_n = 1'b1; rd_n = 1'b1;
        conv_start = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!busy_n) begin
                chk("R7 edge ignored asleep", int'(busy_n), 1);
                break;
            end
        end
        chk("R7 no conversion asleep", int'(busy_n), 1);
        conv_start = 1'b0;
        repeat (3) @(negedge clk);
        pwr_mode = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk("R7 awake after mode high", int'(data_oe), 1);
        cs_n = 1'b1; rd_n = 1'b1;

        // R9 dummy conversion then real one
        run_conv(5000, 1'b0);
        read_chk("R9 dummy", 0, 0);
        run_conv(5000, 1'b0);
        read_chk("R9 first real", exp_code(5000), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule